// File: doc/BRIEF.md
# Backplane Bus Arbiter with Cycle Timer

This block is the system controller of a multi-master backplane. Masters ask for the bus on one of four request levels. When the bus-busy line is low, the arbiter picks one level and drives the grant line for that level. Each grant line runs along a chain of masters sorted by position. The first master on the chain that wants the bus takes the grant and raises bus-busy. Every master before it passes the grant on unchanged, so the master nearest the arbiter wins within a level. The arbiter drops the grant as soon as bus-busy is seen. It makes no new choice until bus-busy has been released and the requests have been sampled again.

The level can be chosen in one of two ways. Under fixed priority the highest level wins. Under rotating selection the search starts one level above the level granted last. The mode is picked by a pin, and a parameter can remove the rotating path altogether.

A separate cycle timer watches the address strobe. If the strobe stays high for a programmed number of clock cycles without an acknowledge, the timer raises bus error. The error stays up until the strobe is removed.

Top module: `bus_arbiter`

## Requirements
- R1: After reset, all four grant outputs and the bus error output are low. At no time is more than one grant output high.
- R2: A grant is chosen at a clock edge where bus-busy is low and at least one request is high. The grant output bit i (bit i belongs to level i) goes high right after that edge, on a level that was requesting.
- R3: A grant output falls at the first clock edge that sees bus-busy high. No grant is issued at any edge where bus-busy is high.
- R4: With the rotate-mode pin low, the highest requesting level wins (level 3 first, level 0 last).
- R5: With the rotate-mode pin high, the search starts at the level after the last one granted and wraps from 3 to 0. After reset the search starts at level 0.
- R6: After bus-busy falls, one clock edge returns the arbiter to idle. A new grant for a request still pending appears after the second edge.
- R7: When the strobe has been high without acknowledge for N consecutive clock edges, where N is a non-zero timeout limit, bus error is high. It stays high while the strobe stays high.
- R8: Bus error falls as soon as the strobe falls. An edge with acknowledge high restarts the count from zero.
- R9: A timeout limit of zero disables the timer, so bus error never rises.
- R10: On a shared level, the master nearest the arbiter on the grant chain gets the bus first. Later masters on that level are served in later cycles.
- R11: If the request of the granted level falls before bus-busy is seen, the grant is withdrawn at the next edge and the arbiter returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 4 | Request per level, active high, bit i is level i |
| bus_busy_i | input | 1 | Bus-busy, high while a master owns the bus |
| rotate_mode_i | input | 1 | 1 selects rotating selection, 0 selects fixed priority |
| strobe_i | input | 1 | Address strobe of the current cycle, active high |
| ack_i | input | 1 | Acknowledge from the addressed slave |
| timeout_limit_i | input | TMR_W | Timeout in clock cycles; 0 disables the timer |
| bus_grant_o | output | 4 | Grant per level, at most one bit high |
| bus_err_o | output | 1 | Bus error raised by the cycle timer |

## Verification
The checker tests these rules on every cycle:
- At most one grant line is high.
- Bus-busy always clears the grant by the next edge.
- Each new grant lands on a level that was requesting, and under fixed priority no higher level was waiting.
- A withdrawal event empties the grant lines.
- Bus error appears only while the strobe is high, never when the limit is zero, and never just after an acknowledge.

Other properties depend on history across many cycles, so only the bench scenarios can show them:
- the full order of service under rotation;
- the nearest-first order within a level, which comes from the daisy chain of bench masters;
- the exact two-edge gap after bus-busy is released;
- the exact edge on which the timeout fires.

A behavioural model in the bench follows every clock edge and covers all of these.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int LVLS  = 4;
  localparam int LVL_W = $clog2(LVLS);

  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [LVLS-1:0]  lvec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_OFFER, ST_OWNED} arb_st_e;

  // highest set bit wins
  function automatic lvl_t pick_fixed(lvec_t req);
    lvl_t r;
    r = '0;
    for (int i = 0; i < LVLS; i++)
      if (req[i]) r = lvl_t'(i);
    return r;
  endfunction

  // first set bit strictly after 'last', wrapping around
  function automatic lvl_t pick_rotate(lvec_t req, lvl_t last);
    lvl_t r;
    lvl_t idx;
    logic hit;
    r   = last;
    hit = 1'b0;
    for (int k = 1; k <= LVLS; k++) begin
      idx = lvl_t'((int'(last) + k) % LVLS);
      if (!hit && req[idx]) begin
        r   = idx;
        hit = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic lvec_t to_onehot(lvl_t l);
    return lvec_t'(1) << l;
  endfunction
endpackage

// File: rtl/arb_level_pick.sv
module arb_level_pick
  import arb_pkg::*;
#(
  parameter bit ROTATE_EN = 1'b1
) (
  input  lvec_t req,
  input  lvl_t  last,
  input  logic  rotate,
  output lvl_t  sel,
  output logic  any
);
  assign any = |req;

  generate
    if (ROTATE_EN) begin : g_both
      assign sel = rotate ? pick_rotate(req, last) : pick_fixed(req);
    end else begin : g_fixed
      lvl_t unused_last;
      logic unused_rot;
      assign unused_last = last;
      assign unused_rot  = rotate;
      assign sel = pick_fixed(req);
    end
  endgenerate
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
  import arb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lvec_t req,
  input  logic  busy,
  input  lvl_t  sel,
  input  logic  any,
  output lvec_t grant,
  output lvl_t  last,
  output logic  issue_evt,
  output logic  drop_evt
);
  arb_st_e st;
  lvl_t    cur;

  assign issue_evt = (st == ST_IDLE) && !busy && any;
  assign drop_evt  = (st == ST_OFFER) && (busy || !req[cur]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      grant <= '0;
      cur   <= '0;
      last  <= lvl_t'(LVLS - 1);
    end else begin
      case (st)
        ST_IDLE: begin
          if (issue_evt) begin
            grant <= to_onehot(sel);
            cur   <= sel;
            last  <= sel;
            st    <= ST_OFFER;
          end
        end
        ST_OFFER: begin
          if (busy) begin
            grant <= '0;
            st    <= ST_OWNED;
          end else if (!req[cur]) begin
            grant <= '0;
            st    <= ST_IDLE;
          end
        end
        ST_OWNED: begin
          if (!busy) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/arb_bus_timer.sv
module arb_bus_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             ack,
  input  logic [TMR_W-1:0] limit,
  output logic             berr
);
  logic [TMR_W-1:0] cnt;

  function automatic logic expired(logic s, logic [TMR_W-1:0] c,
                                   logic [TMR_W-1:0] lim);
    return s && (lim != '0) && (c >= lim);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!strobe || ack)
      cnt <= '0;
    else if (cnt < limit)
      cnt <= cnt + 1'b1;
  end

  assign berr = expired(strobe, cnt, limit);
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import arb_pkg::*;
#(
  parameter int TMR_W     = 16,
  parameter bit ROTATE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       bus_req_i,
  input  logic             bus_busy_i,
  input  logic             rotate_mode_i,
  input  logic             strobe_i,
  input  logic             ack_i,
  input  logic [TMR_W-1:0] timeout_limit_i,
  output logic [3:0]       bus_grant_o,
  output logic             bus_err_o
);
  lvl_t  sel_lvl;
  lvl_t  last_lvl;
  logic  any_req;
  logic  issue_evt;
  logic  drop_evt;
  lvec_t grant_q;

  arb_level_pick #(.ROTATE_EN(ROTATE_EN)) u_pick (
    .req    (bus_req_i),
    .last   (last_lvl),
    .rotate (rotate_mode_i),
    .sel    (sel_lvl),
    .any    (any_req)
  );

  arb_grant_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (bus_req_i),
    .busy      (bus_busy_i),
    .sel       (sel_lvl),
    .any       (any_req),
    .grant     (grant_q),
    .last      (last_lvl),
    .issue_evt (issue_evt),
    .drop_evt  (drop_evt)
  );

  arb_bus_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe_i),
    .ack    (ack_i),
    .limit  (timeout_limit_i),
    .berr   (bus_err_o)
  );

  assign bus_grant_o = grant_q;
endmodule

// File: rtl/bus_arbiter_checker.sv
module bus_arbiter_checker #(
  parameter int TMR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       bus_req_i,
  input logic             bus_busy_i,
  input logic             rotate_mode_i,
  input logic             strobe_i,
  input logic             ack_i,
  input logic [TMR_W-1:0] timeout_limit_i,
  input logic [3:0]       bus_grant_o,
  input logic             bus_err_o,
  input logic             issue_evt,
  input logic             drop_evt
);
  // bits strictly above the single set bit of g
  function automatic logic [3:0] above(logic [3:0] g);
    logic [3:0] m;
    logic seen;
    m    = '0;
    seen = 1'b0;
    for (int i = 0; i < 4; i++) begin
      if (seen) m[i] = 1'b1;
      if (g[i]) seen = 1'b1;
    end
    return m;
  endfunction

  AST_GRANT_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_grant_o)); // R1

  AST_ISSUE_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
    issue_evt |=> ($onehot(bus_grant_o) && ((bus_grant_o & $past(bus_req_i)) != 4'b0))); // R2

  AST_BUSY_CLEARS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy_i |=> (bus_grant_o == 4'b0)); // R3

  AST_FIXED_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_evt && !rotate_mode_i) |=> ((above(bus_grant_o) & $past(bus_req_i)) == 4'b0)); // R4

  AST_DROP_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> (bus_grant_o == 4'b0)); // R11

  AST_BERR_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err_o |-> strobe_i); // R7

  AST_ACK_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && strobe_i && timeout_limit_i != '0) |=> (!bus_err_o || !$stable(timeout_limit_i))); // R8

  AST_ZERO_LIMIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_limit_i == '0) |-> !bus_err_o); // R9
endmodule

bind bus_arbiter bus_arbiter_checker #(.TMR_W(TMR_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bus_req_i       (bus_req_i),
  .bus_busy_i      (bus_busy_i),
  .rotate_mode_i   (rotate_mode_i),
  .strobe_i        (strobe_i),
  .ack_i           (ack_i),
  .timeout_limit_i (timeout_limit_i),
  .bus_grant_o     (bus_grant_o),
  .bus_err_o       (bus_err_o),
  .issue_evt       (issue_evt),
  .drop_evt        (drop_evt)
);

// File: tb/bus_arbiter_tb.sv
module bus_arbiter_tb;
  localparam int TW   = 16;
  localparam int NM   = 6;
  localparam int HOLD = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    bus_req;
  logic          bus_busy;
  logic          rotate_mode = 1'b0;
  logic          strobe = 1'b0;
  logic          ack = 1'b0;
  logic [TW-1:0] limit = 16'd5;
  logic [3:0]    bus_grant;
  logic          bus_err;

  logic [3:0] frc_req = 4'b0;
  logic       frc_busy = 1'b0;
  logic [3:0] m_req = 4'b0;
  logic       m_busy = 1'b0;
  assign bus_req  = m_req | frc_req;
  assign bus_busy = m_busy | frc_busy;

  always #4 clk = ~clk;

  bus_arbiter #(.TMR_W(TW)) u_dut (
    .clk (clk), .rst_n (rst_n), .bus_req_i (bus_req), .bus_busy_i (bus_busy),
    .rotate_mode_i (rotate_mode), .strobe_i (strobe), .ack_i (ack),
    .timeout_limit_i (limit), .bus_grant_o (bus_grant), .bus_err_o (bus_err)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int md_st = 0;
  int md_g = -1;
  int md_last = 3;
  int md_cnt = 0;

  function automatic int ref_fixed(logic [3:0] r);
    for (int i = 3; i >= 0; i--) if (r[i]) return i;
    return -1;
  endfunction

  function automatic int ref_rot(logic [3:0] r, int last);
    for (int k = 1; k <= 4; k++) if (r[(last + k) % 4]) return (last + k) % 4;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      md_st = 0; md_g = -1; md_last = 3; md_cnt = 0;
    end else begin
      case (md_st)
        0: if (!bus_busy && bus_req != 0) begin
             md_g = rotate_mode ? ref_rot(bus_req, md_last) : ref_fixed(bus_req);
             md_last = md_g; md_st = 1;
           end
        1: if (bus_busy) begin md_g = -1; md_st = 2; end
           else if (!bus_req[md_g]) begin md_g = -1; md_st = 0; end
        2: if (!bus_busy) md_st = 0;
        default: md_st = 0;
      endcase
      if (!strobe || ack) md_cnt = 0;
      else if (md_cnt < int'(limit)) md_cnt++;
    end
  end

  // ---------------- requester chain ----------------
  int m_lvl[NM] = '{3, 1, 3, 0, 2, 1};
  bit m_want[NM];
  bit m_own[NM];
  int m_hold[NM];
  int claim_q[$];
  int gap_q[$];
  int since_rel = -1;
  bit start_all = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NM; i++) begin m_want[i] = 0; m_own[i] = 0; m_hold[i] = 0; end
      since_rel = -1;
    end else begin
      logic [3:0] expg;
      bit expe;
      bit released;
      bit pending;
      expg = (md_g < 0) ? 4'b0 : (4'b1 << md_g);
      expe = strobe && (limit != 0) && (md_cnt >= int'(limit));
      check(bus_grant === expg, "R1/R2/R3/R6 grant vs model", bus_grant, expg);
      check(bus_err === expe, "R7/R8/R9 berr vs model", bus_err, expe);
      if (since_rel >= 0) begin
        since_rel++;
        if (bus_grant != 0) begin gap_q.push_back(since_rel); since_rel = -1; end
      end
      if (start_all) begin
        for (int i = 0; i < NM; i++) m_want[i] = 1;
        start_all = 0;
      end
      released = 0;
      for (int i = 0; i < NM; i++)
        if (m_own[i]) begin
          m_hold[i]--;
          if (m_hold[i] == 0) begin m_own[i] = 0; m_want[i] = 0; released = 1; end
        end
      for (int l = 0; l < 4; l++) begin
        bit g;
        g = bus_grant[l];
        for (int i = 0; i < NM; i++)
          if (m_lvl[i] == l) begin
            if (g && m_want[i] && !bus_busy) begin
              m_own[i] = 1; m_hold[i] = HOLD; claim_q.push_back(i);
            end
            if (m_want[i]) g = 0;
          end
      end
      pending = 0;
      for (int i = 0; i < NM; i++) if (m_want[i] && !m_own[i]) pending = 1;
      if (released && pending) since_rel = 0;
      m_req = 4'b0;
      m_busy = 0;
      for (int i = 0; i < NM; i++) begin
        if (m_want[i]) m_req[m_lvl[i]] = 1'b1;
        if (m_own[i]) m_busy = 1'b1;
      end
    end
  end

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    #2;
  endtask

  task automatic run_all(input int exp[NM], input string tag);
    claim_q.delete();
    gap_q.delete();
    start_all = 1;
    while (claim_q.size() < NM) tick();
    repeat (HOLD + 3) tick();
    for (int i = 0; i < NM; i++)
      check(claim_q[i] == exp[i], tag, claim_q[i], exp[i]);
    foreach (gap_q[i]) check(gap_q[i] == 2, "R6 release-to-grant gap", gap_q[i], 2);
  endtask

  initial begin
    repeat (3) tick();
    check(bus_grant == 4'b0, "R1 reset grant", bus_grant, 0);
    check(bus_err == 1'b0, "R1 reset berr", bus_err, 0);
    rst_n = 1;
    tick();

    // fixed priority: L3 chain m0 before m2 (R10), then L2, L1 (m1 before m5), L0
    rotate_mode = 0;
    run_all('{0, 2, 4, 1, 5, 3}, "R4/R10 fixed order");

    // rotating selection from a fresh reset
    rst_n = 0; tick(); rst_n = 1; tick();
    rotate_mode = 1;
    run_all('{3, 1, 4, 0, 5, 2}, "R5/R10 rotate order");

    // withdrawal when nobody claims (R11)
    frc_req = 4'b0100;
    tick();
    check(bus_grant == 4'b0100, "R2 grant to lone requester", bus_grant, 4);
    frc_req = 4'b0;
    tick();
    check(bus_grant == 4'b0, "R11 grant withdrawn", bus_grant, 0);

    // busy held by someone else blocks grants (R3)
    frc_busy = 1; frc_req = 4'b0001;
    repeat (3) tick();
    check(bus_grant == 4'b0, "R3 no grant while busy", bus_grant, 0);
    frc_busy = 0;
    tick();
    check(bus_grant == 4'b0001, "R2 grant after busy low", bus_grant, 1);
    frc_req = 4'b0;
    repeat (2) tick();

    // timer
    limit = 16'd5;
    strobe = 1;
    repeat (4) tick();
    check(bus_err == 1'b0, "R7 berr before limit", bus_err, 0);
    tick();
    check(bus_err == 1'b1, "R7 berr at limit", bus_err, 1);
    tick();
    check(bus_err == 1'b1, "R7 berr held", bus_err, 1);
    strobe = 0;
    #1;
    check(bus_err == 1'b0, "R8 berr falls with strobe", bus_err, 0);
    tick();
    strobe = 1;
    repeat (3) tick();
    ack = 1;
    tick();
    ack = 0;
    repeat (4) tick();
    check(bus_err == 1'b0, "R8 ack restarts count", bus_err, 0);
    tick();
    check(bus_err == 1'b1, "R8 berr after restart", bus_err, 1);
    strobe = 0;
    tick();
    limit = 16'd0;
    strobe = 1;
    repeat (30) tick();
    check(bus_err == 1'b0, "R9 zero limit disables", bus_err, 0);
    strobe = 0;
    repeat (2) tick();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule